// File: doc/BRIEF.md
# Host-to-Card Memory Window Translator

This block sits between a host memory bus and a removable card slot. It compares every host address with four programmable memory windows. When the address lands in an enabled window, the block signals a hit. It also produces the card-side address and tells the card which memory space to use and how wide the data path is.

Each window holds three page values, all in 4 KB units:

- a first page;
- a last page, which is inclusive;
- a two's-complement page displacement.

To form the card address, the block adds the displacement to the host page and keeps the byte-within-page bits unchanged. A few flag bits ride in the upper bits of the page bytes: the 16-bit data path, the timer set and the attribute-space select. Software programs everything through an indexed byte-wide write port. A single enable byte turns each memory window on or off and also carries the enable for the first I/O window.

Top module: `host_card_window_xlate`

## Requirements
- R1: After a synchronous reset, every window setting and every enable bit reads as zero. `hit` and `io0_en` are then low for any host address.
- R2: A byte written through the port takes effect on the clock edge that samples `reg_we`. The outputs then follow `host_addr` combinationally, with no further clock.
- R3: Window n owns register indices 0x10+8n to 0x10+8n+5, in this order: first-page low byte, first-page high byte, last-page low byte, last-page high byte, displacement low byte, displacement high byte. Each low byte holds page bits 7:0 (address bits 19:12). First and last page high bytes hold page bits 11:8 in bits 3:0. The displacement high byte holds displacement bits 12:8 in bits 4:0.
- R4: An enabled window hits when the host page (`host_addr[23:12]`) is at least its first page and at most its last page; both limits are inclusive.
- R5: `card_addr[24:12]` equals (host page + displacement) modulo 2^13. `card_addr[11:0]` equals `host_addr[11:0]`. A displacement with bit 12 set acts as a negative page offset.
- R6: `attr_sel` is bit 6 of the winning window's displacement high byte.
- R7: `wide16` is bit 7 of the winning window's first-page high byte, and `timer_sel` is bit 6 of its last-page high byte.
- R8: The enable byte sits at index 0x06, and its bits 3:0 enable windows 0 to 3. A window whose bit is clear never produces a hit, whatever its settings.
- R9: `io0_en` is bit 6 of the enable byte.
- R10: When several enabled windows contain the host page, the lowest-numbered one supplies every output.
- R11: Writes to index slots 6 and 7 of a window, or to any index outside the map, change no output.
- R12: Without a hit, `card_addr`, `attr_sel`, `wide16` and `timer_sel` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 8 | Register index |
| reg_wdata | input | 8 | Register write data |
| host_addr | input | 24 | Host memory address |
| hit | output | 1 | Address falls in an enabled window |
| card_addr | output | 25 | Translated card address |
| attr_sel | output | 1 | Attribute memory select (0 = common memory) |
| wide16 | output | 1 | 16-bit data path select |
| timer_sel | output | 1 | Timer set select |
| io0_en | output | 1 | I/O window 0 enable |

## Verification
Register writes are the only timed path.

- **Register writes:** a byte driven on the falling edge is captured by the next rising edge. Its effect is checked half a period later, at the following falling edge.
- **Translation:** this is zero cycles from `host_addr`. The bench changes the address away from any rising edge and compares all outputs a quarter period later, before the next edge. No check can therefore see a stale register or a value caught in the middle of an edge.
- **Reset:** checked the same way, one rising edge after `rst` is asserted.

// File: rtl/hcw_pkg.sv
package hcw_pkg;
    localparam int NUM_WIN    = 4;
    localparam int HOST_AW    = 24;
    localparam int PAGE_SH    = 12;
    localparam int OFF_PW     = 13;
    localparam int HPAGE_W    = HOST_AW - PAGE_SH;
    localparam int CARD_AW    = OFF_PW + PAGE_SH;
    localparam int WIN_STRIDE = 8;
    localparam int SLOT_W     = $clog2(WIN_STRIDE);
    localparam logic [7:0] WIN_BASE = 8'h10;
    localparam logic [7:0] ENA_IDX  = 8'h06;
    localparam int IO0_BIT    = 6;

    typedef enum logic [SLOT_W-1:0] {
        SL_FIRST_LO = 3'd0,
        SL_FIRST_HI = 3'd1,
        SL_LAST_LO  = 3'd2,
        SL_LAST_HI  = 3'd3,
        SL_DISP_LO  = 3'd4,
        SL_DISP_HI  = 3'd5
    } slot_e;

    typedef struct packed {
        logic [HPAGE_W-1:0] first;
        logic [HPAGE_W-1:0] last;
        logic [OFF_PW-1:0]  disp;
        logic               wide;
        logic               timer;
        logic               attr;
    } win_cfg_t;

    typedef struct packed {
        logic               hit;
        logic [CARD_AW-1:0] card;
        logic               attr;
        logic               wide;
        logic               timer;
    } xlate_t;

    function automatic logic [OFF_PW-1:0] page_add(
        input logic [HPAGE_W-1:0] hpage,
        input logic [OFF_PW-1:0]  disp
    );
        return OFF_PW'(hpage) + disp;
    endfunction
endpackage

// File: rtl/hcw_regs.sv
module hcw_regs
    import hcw_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_we,
    input  logic [7:0]         reg_idx,
    input  logic [7:0]         reg_wdata,
    output win_cfg_t           cfg [NUM_WIN],
    output logic [NUM_WIN-1:0] win_en,
    output logic               io0_en
);
    localparam int FHI_W = HPAGE_W - 8;
    localparam int DHI_W = OFF_PW - 8;

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        localparam logic [7:0] BASE = WIN_BASE + 8'(g * WIN_STRIDE);
        logic  wsel;
        slot_e slot;
        assign wsel = reg_we && (reg_idx[7:SLOT_W] == BASE[7:SLOT_W]);
        assign slot = slot_e'(reg_idx[SLOT_W-1:0]);

        always_ff @(posedge clk) begin
            if (rst) begin
                cfg[g] <= '0;
            end else if (wsel) begin
                case (slot)
                    SL_FIRST_LO: cfg[g].first[7:0] <= reg_wdata;
                    SL_FIRST_HI: begin
                        cfg[g].first[HPAGE_W-1:8] <= reg_wdata[FHI_W-1:0];
                        cfg[g].wide               <= reg_wdata[7];
                    end
                    SL_LAST_LO:  cfg[g].last[7:0] <= reg_wdata;
                    SL_LAST_HI: begin
                        cfg[g].last[HPAGE_W-1:8] <= reg_wdata[FHI_W-1:0];
                        cfg[g].timer             <= reg_wdata[6];
                    end
                    SL_DISP_LO:  cfg[g].disp[7:0] <= reg_wdata;
                    SL_DISP_HI: begin
                        cfg[g].disp[OFF_PW-1:8] <= reg_wdata[DHI_W-1:0];
                        cfg[g].attr             <= reg_wdata[6];
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            win_en <= '0;
            io0_en <= 1'b0;
        end else if (reg_we && reg_idx == ENA_IDX) begin
            win_en <= reg_wdata[NUM_WIN-1:0];
            io0_en <= reg_wdata[IO0_BIT];
        end
    end

    AST_ENA_WRITE_NEXT: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_idx == ENA_IDX) |=> (win_en == $past(reg_wdata[NUM_WIN-1:0]))); // R2
endmodule

// File: rtl/hcw_match.sv
module hcw_match
    import hcw_pkg::*;
(
    input  win_cfg_t             cfg,
    input  logic                 en,
    input  logic [HOST_AW-1:0]   host_addr,
    output xlate_t               res
);
    logic [HPAGE_W-1:0] hpage;
    assign hpage = host_addr[HOST_AW-1:PAGE_SH];

    always_comb begin
        res.hit   = en && (hpage >= cfg.first) && (hpage <= cfg.last);
        res.card  = {page_add(hpage, cfg.disp), host_addr[PAGE_SH-1:0]};
        res.attr  = cfg.attr;
        res.wide  = cfg.wide;
        res.timer = cfg.timer;
    end
endmodule

// File: rtl/hcw_prio.sv
module hcw_prio
    import hcw_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  xlate_t cand [NUM_WIN],
    output xlate_t pick
);
    always_comb begin
        pick = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (cand[i].hit) pick = cand[i];
        end
    end

    AST_FIRST_WINS: assert property (@(posedge clk) disable iff (rst)
        cand[0].hit |-> (pick.card == cand[0].card && pick.attr == cand[0].attr)); // R10
endmodule

// File: rtl/host_card_window_xlate.sv
module host_card_window_xlate
    import hcw_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_we,
    input  logic [7:0]         reg_idx,
    input  logic [7:0]         reg_wdata,
    input  logic [HOST_AW-1:0] host_addr,
    output logic               hit,
    output logic [CARD_AW-1:0] card_addr,
    output logic               attr_sel,
    output logic               wide16,
    output logic               timer_sel,
    output logic               io0_en
);
    win_cfg_t           cfg  [NUM_WIN];
    logic [NUM_WIN-1:0] win_en;
    xlate_t             cand [NUM_WIN];
    xlate_t             pick;

    hcw_regs u_regs (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .cfg(cfg), .win_en(win_en), .io0_en(io0_en)
    );

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_match
        hcw_match u_match (
            .cfg(cfg[g]), .en(win_en[g]), .host_addr(host_addr), .res(cand[g])
        );
    end

    hcw_prio u_prio (.clk(clk), .rst(rst), .cand(cand), .pick(pick));

    assign hit       = pick.hit;
    assign card_addr = pick.card;
    assign attr_sel  = pick.attr;
    assign wide16    = pick.wide;
    assign timer_sel = pick.timer;

    AST_NO_HIT_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        (win_en == '0) |-> !hit); // R8
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !hit |-> (card_addr == '0 && !attr_sel && !wide16 && !timer_sel)); // R12
endmodule

// File: tb/test_host_card_window_xlate.sv
`timescale 1ns/100ps
module test_host_card_window_xlate;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_idx = '0;
    logic [7:0]  reg_wdata = '0;
    logic [23:0] host_addr = '0;
    logic        hit, attr_sel, wide16, timer_sel, io0_en;
    logic [24:0] card_addr;
    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    host_card_window_xlate i_host_card_window_xlate (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .host_addr(host_addr), .hit(hit),
        .card_addr(card_addr), .attr_sel(attr_sel), .wide16(wide16),
        .timer_sel(timer_sel), .io0_en(io0_en)
    );

    localparam int NV = 10;
    localparam logic [23:0] VA [NV] = '{24'h00FFFF, 24'h010000, 24'h01F7FF, 24'h018123,
        24'h020456, 24'h02FFFF, 24'h030000, 24'hF00ABC, 24'hFFF123, 24'h500010};
    localparam logic [24:0] VC [NV] = '{25'h0, 25'h110000, 25'h11F7FF, 25'h118123,
        25'h010456, 25'h01FFFF, 25'h0, 25'h100ABC, 25'h1FF123, 25'h0};
    // flags {hit, attr, wide, timer}
    localparam logic [3:0] VF [NV] = '{4'b0000, 4'b1010, 4'b1010, 4'b1010,
        4'b1101, 4'b1101, 4'b0000, 4'b1010, 4'b1010, 4'b0000};
    localparam string VR [NV] = '{"R4 below", "R4 R5 first", "R4 R5 last", "R10 overlap",
        "R5 R6 neg disp", "R7 last", "R12 miss", "R5 wrap", "R5 wrap top", "R8 disabled"};

    task automatic chk(input string req, input logic [23:0] a,
                       input logic [24:0] ec, input logic [3:0] ef);
        host_addr = a;
        #1.2;
        checks++;
        if ({hit, attr_sel, wide16, timer_sel} !== ef || card_addr !== ec) begin
            errors++;
            $display("FAIL %s addr=%h got card=%h flags=%b exp card=%h flags=%b",
                     req, a, card_addr, {hit, attr_sel, wide16, timer_sel}, ec, ef);
        end
    endtask

    task automatic chk_io(input string req, input logic exp);
        checks++;
        if (io0_en !== exp) begin
            errors++;
            $display("FAIL %s io0_en got=%b exp=%b", req, io0_en, exp);
        end
    endtask

    task automatic wr(input logic [7:0] idx, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_idx = idx; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    initial begin
        #100000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk("R1 reset", 24'h010000, 25'h0, 4'b0000);
        chk_io("R1 reset", 1'b0);
        // R3 window programming
        wr(8'h10, 8'h10); wr(8'h11, 8'h80); wr(8'h12, 8'h1F); wr(8'h13, 8'h00);
        wr(8'h14, 8'h00); wr(8'h15, 8'h01);
        wr(8'h18, 8'h18); wr(8'h19, 8'h00); wr(8'h1A, 8'h2F); wr(8'h1B, 8'h40);
        wr(8'h1C, 8'hF0); wr(8'h1D, 8'h5F);
        wr(8'h20, 8'h00); wr(8'h21, 8'h8F); wr(8'h22, 8'hFF); wr(8'h23, 8'h0F);
        wr(8'h24, 8'h00); wr(8'h25, 8'h12);
        wr(8'h28, 8'h00); wr(8'h29, 8'h85); wr(8'h2A, 8'h00); wr(8'h2B, 8'h45);
        wr(8'h2C, 8'h00); wr(8'h2D, 8'h40);
        chk("R8 none enabled", 24'h010000, 25'h0, 4'b0000);
        wr(8'h06, 8'h47);
        chk_io("R9 set", 1'b1);
        for (int i = 0; i < NV; i++) chk(VR[i], VA[i], VC[i], VF[i]);
        // R2: enable write visible next edge
        host_addr = 24'h500010;
        @(negedge clk);
        reg_we = 1'b1; reg_idx = 8'h06; reg_wdata = 8'h0F;
        @(negedge clk);
        reg_we = 1'b0;
        chk("R2 R7 single page", 24'h500010, 25'h500010, 4'b1111);
        chk_io("R9 clear", 1'b0);
        // R10: window 0 off, window 1 takes overlap
        wr(8'h06, 8'h0E);
        chk("R10 next window", 24'h018123, 25'h008123, 4'b1101);
        wr(8'h06, 8'h0F);
        // R11: ignored writes
        wr(8'h16, 8'hFF); wr(8'h17, 8'hFF); wr(8'h00, 8'hFF); wr(8'h30, 8'hFF); wr(8'h07, 8'h00);
        chk("R11 ignored", 24'h010000, 25'h110000, 4'b1010);
        chk("R11 ignored w3", 24'h500010, 25'h500010, 4'b1111);
        // R1: reset mid-run
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk("R1 re-reset", 24'h500010, 25'h0, 4'b0000);
        chk_io("R1 re-reset", 1'b0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule